// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block sits between a requester and a register whose reads are sometimes corrupted in transit. A single read request does not return one sample. Instead the block collects a series of samples of the same register and keeps a small table of the distinct values it has seen, with a tally for each. It returns the value that occurred most often.

It stops sampling as soon as one value has been seen in more than half of the planned sample count, because no other value can then overtake it. If no value gets that far, the block takes the full planned number of samples and returns the leader. When two values tie for the lead, the one that reached that count first wins.

The requester raises `readReq` while the block is idle. The block then asserts `sampleReq` toward the register source and accepts one sample on each cycle where `sampleValid` is high. When it finishes, it pulses `done` for one cycle and drives `result`, `resultCount` and `discardCount`.

Top module: `majority_read_filter`

## Requirements
- R1: After reset, `busy`, `done` and `sampleReq` are all low.
- R2: A `readReq` seen while idle clears the tally table. On the next cycle `busy` and `sampleReq` are high.
- R3: A `readReq` raised while `busy` is high (during sampling or in the `done` cycle) has no effect. The run in progress completes unchanged, and the block returns to idle with no new run started.
- R4: If no value exceeds half of `NUM_SAMPLES`, exactly `NUM_SAMPLES` samples are accepted. `result` is the value with the highest tally.
- R5: Sampling stops with the sample that gives some value a tally of `NUM_SAMPLES/2 + 1`. That value is returned and no further samples are accepted.
- R6: When values tie for the highest tally, the one whose tally reached that level first is returned.
- R7: Once `TABLE_DEPTH` distinct values are stored, a sample with an unseen value takes no slot. It is counted in `discardCount` and can never be returned. `discardCount` holds its value while idle.
- R8: `done` is high for exactly one cycle per run. In that cycle `result`, `resultCount` and `discardCount` are valid and `sampleReq` is low. In the following cycle `busy` is low.
- R9: A cycle in which `sampleReq` is high but `sampleValid` is low is not counted as a sample.
- R10: At `done`, `resultCount` equals the number of accepted samples carrying `result`. It lies between 1 and `NUM_SAMPLES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| readReq | input | 1 | Start a filtered read (honoured only while idle) |
| sampleValid | input | 1 | A register sample is present on `sampleData` |
| sampleData | input | DATA_W | Sampled register value |
| sampleReq | output | 1 | The block wants samples from the source |
| busy | output | 1 | A run is in progress (including the `done` cycle) |
| done | output | 1 | One-cycle pulse marking the result valid |
| result | output | DATA_W | Most frequent sampled value |
| resultCount | output | CNT_W | Tally of `result` |
| discardCount | output | CNT_W | Samples dropped because the table was full |

## Verification
The hardest condition to reach is a full table that then receives more unseen values, while a tie for the lead is still open. Random sampling from a few values almost never fills the table. The stimulus therefore mixes directed sequences with random runs. The directed sequences cycle through more distinct values than the table holds, or alternate two values exactly evenly. The random runs draw from alphabets of up to twelve values with a tunable bias toward one of them, and insert random idle cycles on `sampleValid`.

// File: rtl/mvf_pkg.sv
package mvf_pkg;
  typedef struct packed {
    logic clear;
    logic accept;
  } mvf_ctrl_t;

  typedef struct packed {
    logic stop;
  } mvf_stat_t;
endpackage

// File: rtl/mvf_datapath.sv
module mvf_datapath
  import mvf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_SAMPLES = 100,
  parameter int TABLE_DEPTH = 8,
  localparam int CNT_W      = $clog2(NUM_SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mvf_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] sampleData,
  output mvf_stat_t         stat,
  output logic [DATA_W-1:0] result,
  output logic [CNT_W-1:0]  resultCount,
  output logic [CNT_W-1:0]  discardCount
);
  localparam int IDX_W  = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1;
  localparam int USED_W = $clog2(TABLE_DEPTH + 1);
  localparam int HALF   = NUM_SAMPLES / 2;

  logic [DATA_W-1:0] valTab [TABLE_DEPTH];
  logic [CNT_W-1:0]  cntTab [TABLE_DEPTH];
  logic [USED_W-1:0] used;
  logic [IDX_W-1:0]  maxIdx;
  logic [CNT_W-1:0]  maxCnt;
  logic [CNT_W-1:0]  smpCnt;
  logic [CNT_W-1:0]  discCnt;

  logic [TABLE_DEPTH-1:0] hitVec;
  logic [IDX_W-1:0]       hitIdx;
  logic [IDX_W-1:0]       slotIdx;
  logic [CNT_W-1:0]       newCnt;
  logic hit, room, takes, better, lastOne;

  // parallel compare against every occupied slot
  for (genvar g = 0; g < TABLE_DEPTH; g++) begin : gCmp
    assign hitVec[g] = (USED_W'(g) < used) && (valTab[g] == sampleData);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = TABLE_DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hit     = |hitVec;
  assign room    = used < USED_W'(TABLE_DEPTH);
  assign takes   = hit || room;
  assign slotIdx = hit ? hitIdx : used[IDX_W-1:0];
  assign newCnt  = hit ? cntTab[hitIdx] + CNT_W'(1) : CNT_W'(1);
  // strict compare keeps the earlier leader on a tie
  assign better  = takes && (newCnt > maxCnt);
  assign lastOne = smpCnt == CNT_W'(NUM_SAMPLES - 1);
  assign stat.stop = ctrl.accept && (lastOne || (better && newCnt > CNT_W'(HALF)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_DEPTH; i++) begin
        valTab[i] <= '0;
        cntTab[i] <= '0;
      end
      used    <= '0;
      maxIdx  <= '0;
      maxCnt  <= '0;
      smpCnt  <= '0;
      discCnt <= '0;
    end else if (ctrl.clear) begin
      used    <= '0;
      maxIdx  <= '0;
      maxCnt  <= '0;
      smpCnt  <= '0;
      discCnt <= '0;
    end else if (ctrl.accept) begin
      smpCnt <= smpCnt + CNT_W'(1);
      if (takes) begin
        valTab[slotIdx] <= sampleData;
        cntTab[slotIdx] <= newCnt;
        if (!hit) used <= used + USED_W'(1);
      end else begin
        discCnt <= discCnt + CNT_W'(1);
      end
      if (better) begin
        maxCnt <= newCnt;
        maxIdx <= slotIdx;
      end
    end
  end

  assign result       = valTab[maxIdx];
  assign resultCount  = maxCnt;
  assign discardCount = discCnt;
endmodule

// File: rtl/mvf_control.sv
module mvf_control
  import mvf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      readReq,
  input  logic      sampleValid,
  input  mvf_stat_t stat,
  output mvf_ctrl_t ctrl,
  output logic      sampleReq,
  output logic      busy,
  output logic      done
);
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_DONE} state_t;
  state_t state, stateNext;

  always_comb begin
    ctrl.clear  = (state == ST_IDLE) && readReq;
    ctrl.accept = (state == ST_SAMPLE) && sampleValid;
    stateNext   = state;
    unique case (state)
      ST_IDLE:   if (readReq) stateNext = ST_SAMPLE;
      ST_SAMPLE: if (stat.stop) stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign sampleReq = state == ST_SAMPLE;
  assign busy      = state != ST_IDLE;
  assign done      = state == ST_DONE;
endmodule

// File: rtl/majority_read_filter.sv
module majority_read_filter
  import mvf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_SAMPLES = 100,
  parameter int TABLE_DEPTH = 8,
  localparam int CNT_W      = $clog2(NUM_SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readReq,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sampleReq,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [CNT_W-1:0]  resultCount,
  output logic [CNT_W-1:0]  discardCount
);
  mvf_ctrl_t ctrl;
  mvf_stat_t stat;

  mvf_control uCtrl (
    .clk(clk), .rstN(rstN), .readReq(readReq), .sampleValid(sampleValid),
    .stat(stat), .ctrl(ctrl), .sampleReq(sampleReq), .busy(busy), .done(done)
  );

  mvf_datapath #(
    .DATA_W(DATA_W), .NUM_SAMPLES(NUM_SAMPLES), .TABLE_DEPTH(TABLE_DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleData(sampleData), .stat(stat),
    .result(result), .resultCount(resultCount), .discardCount(discardCount)
  );
endmodule

// File: rtl/mvf_checker.sv
module mvf_checker #(
  parameter int NUM_SAMPLES = 100,
  parameter int CNT_W       = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             readReq,
  input logic             sampleReq,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] resultCount,
  input logic [CNT_W-1:0] discardCount
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r8_no_strobe_in_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !sampleReq);
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && readReq) |=> (busy && sampleReq));
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r10_count_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resultCount != '0 && resultCount <= CNT_W'(NUM_SAMPLES)));
  a_r7_discard_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !readReq) |=> $stable(discardCount));
endmodule

bind majority_read_filter mvf_checker #(
  .NUM_SAMPLES(NUM_SAMPLES), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .readReq(readReq), .sampleReq(sampleReq),
  .busy(busy), .done(done), .resultCount(resultCount), .discardCount(discardCount)
);

// File: tb/tb_majority_read_filter.sv
module tb_majority_read_filter;
  localparam int DW = 32;
  localparam int NS = 100;
  localparam int TD = 8;
  localparam int CW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readReq = 1'b0;
  logic sampleValid = 1'b0;
  logic [DW-1:0] sampleData = '0;
  logic sampleReq, busy, done;
  logic [DW-1:0] result;
  logic [CW-1:0] resultCount, discardCount;

  int checks = 0;
  int bad = 0;

  logic [DW-1:0] seq [NS];
  logic [DW-1:0] expVal;
  int expCnt, expDisc, expUsed;

  always #10 clk = ~clk;

  majority_read_filter #(.DATA_W(DW), .NUM_SAMPLES(NS), .TABLE_DEPTH(TD)) dut (
    .clk(clk), .rstN(rstN), .readReq(readReq), .sampleValid(sampleValid),
    .sampleData(sampleData), .sampleReq(sampleReq), .busy(busy), .done(done),
    .result(result), .resultCount(resultCount), .discardCount(discardCount)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected outcome from the requirements: mode of the consumed prefix
  task automatic model();
    logic [DW-1:0] vals [TD];
    int cnts [TD];
    int used = 0, maxc = 0, maxi = 0, nc, j;
    expDisc = 0;
    expUsed = NS;
    for (int i = 0; i < TD; i++) begin vals[i] = '0; cnts[i] = 0; end
    for (int i = 0; i < NS; i++) begin
      j = -1;
      for (int k = 0; k < used; k++) if (vals[k] == seq[i]) j = k;
      if (j >= 0) begin
        cnts[j]++; nc = cnts[j];
      end else if (used < TD) begin
        vals[used] = seq[i]; cnts[used] = 1; j = used; used++; nc = 1;
      end else begin
        expDisc++; nc = 0;
      end
      if (nc > maxc) begin maxc = nc; maxi = j; end
      if (maxc > NS / 2) begin expUsed = i + 1; break; end
    end
    expVal = vals[maxi];
    expCnt = maxc;
  endtask

  // runs one filtered read; gapPct inserts idle sample cycles, poke raises readReq mid-run
  task automatic runRead(input string tag, input int gapPct, input bit poke);
    int idx = 0;
    model();
    @(negedge clk);
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    check(busy && sampleReq, "R2 start", {busy, sampleReq}, 3);
    while (!done) begin
      if (sampleReq) begin
        if (int'($urandom % 100) < gapPct) begin
          sampleValid = 1'b0;
        end else begin
          sampleValid = 1'b1;
          sampleData  = seq[(idx < NS) ? idx : 0];
        end
        if (poke && idx == 10) readReq = 1'b1;
      end
      @(posedge clk);
      if (sampleValid) idx++;
      @(negedge clk);
      sampleValid = 1'b0;
      readReq = 1'b0;
    end
    check(result == expVal, {tag, " R4 R5 R6 result"}, result, expVal);
    check(int'(resultCount) == expCnt, {tag, " R10 resultCount"}, resultCount, expCnt);
    check(int'(discardCount) == expDisc, {tag, " R7 discardCount"}, discardCount, expDisc);
    check(idx == expUsed, {tag, " R9 R5 samples consumed"}, idx, expUsed);
    check(!sampleReq, "R8 no strobe in done", sampleReq, 0);
    readReq = 1'b1;  // R3: request during the done cycle must be dropped
    @(negedge clk);
    readReq = 1'b0;
    check(!done && !busy, "R8 R3 idle after done", {done, busy}, 0);
    @(negedge clk);
    check(!busy && !sampleReq, "R3 no restart", {busy, sampleReq}, 0);
    check(int'(discardCount) == expDisc, "R7 discardCount held idle", discardCount, expDisc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && !sampleReq, "R1 reset state", {busy, done, sampleReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !sampleReq, "R1 after release", {busy, done, sampleReq}, 0);

    // R5: one value throughout, stops at 51
    for (int i = 0; i < NS; i++) seq[i] = 32'hA5A5_0001;
    runRead("const", 0, 1'b0);
    check(expUsed == NS / 2 + 1, "R5 early stop point", expUsed, NS / 2 + 1);

    // R4 R6: exact 50/50 alternation, first value wins the tie
    for (int i = 0; i < NS; i++) seq[i] = (i % 2 == 0) ? 32'h0000_1111 : 32'h0000_2222;
    runRead("tie", 0, 1'b0);
    check(expVal == 32'h0000_1111, "R6 tie keeps earlier", expVal, 32'h1111);

    // R9 R3: same with stalls and a request poked mid-run
    runRead("tie-gaps", 35, 1'b1);

    // R7: twelve distinct values cycling through an eight-slot table
    for (int i = 0; i < NS; i++) seq[i] = 32'h100 + 32'(i % 12);
    runRead("overflow", 10, 1'b0);
    check(expDisc == 32, "R7 discard total", expDisc, 32);

    // R5 at the final sample
    seq[0] = 32'hB;
    for (int i = 1; i < 50; i++) seq[i] = 32'hA;
    for (int i = 50; i < NS; i++) seq[i] = 32'hB;
    runRead("late-major", 0, 1'b0);

    // random runs over small alphabets with a biased favourite
    for (int r = 0; r < 24; r++) begin
      int k = 1 + int'($urandom % 12);
      int bias = int'($urandom % 80);
      logic [DW-1:0] fav = $urandom;
      for (int i = 0; i < NS; i++)
        seq[i] = (int'($urandom % 100) < bias) ? fav : 32'hC000 + 32'($urandom % k);
      runRead("random", int'($urandom % 40), r[0]);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule